// File: doc/BRIEF.md
# Leveled Interrupt Priority Controller

This block gathers interrupt requests for a processor core. Every priority level owns a wide source word in which each bit is one requester. A per-level pending bit is set when any source in that level is active. Commands on the command port post a source, clear a source, or wipe all levels at once. A posted source is named by a level number and a bit index.

On every clock edge the block resolves one priority and one summary mask. Two inputs feed this step: a range of pending levels treated as external, and a software request vector. Software bit `i` maps to priority `i - SW_MIN + 1`, and external level `i` maps to priority `i`. The highest active external level takes precedence over any software request. The resolved priority raises a take-interrupt pulse only when it is nonzero and strictly above the core's current priority level. In that case the priority and mask are latched into holding registers. When the core acknowledges, the held pair is copied to the interrupt-id and interrupt-summary outputs. A separate indication tells the core that an interrupt may be taken at the current instruction boundary.

A sticky error flag records requests the block cannot honour: commands that are out of range, acknowledges with nothing held, and asynchronous trap requests.

Top module: `irq_level_ctrl`

## Requirements
- R1: A post with level `l < NUM_LEVELS` and index `k < SRC_W` sets bit `k` of level `l`'s source word, and `pend_levels[l]` is 1 after that edge.
- R2: A clear with an in-range (level, index) clears that source bit. `pend_levels[l]` falls only when level `l`'s whole source word is zero afterwards.
- R3: `clr_all` zeroes every source word and `pend_levels` at one edge, and takes priority over a post or clear in the same cycle.
- R4: `int_possible` is 1 one edge after a cycle in which `pend_levels` was nonzero and `pc_low == 2'b00`, and is 0 otherwise.
- R5: For each set `sw_req[i]` with `SW_MIN <= i < SW_MAX`, the candidate priority is `i - SW_MIN + 1`, and bit `i` of the summary mask is set. The highest such bit gives the software priority.
- R6: For each pending level `i` with `EXT_MIN <= i < EXT_MAX`, the candidate priority is `i`, and bit `i` of the summary mask is set. The highest pending external level overrides the software priority.
- R7: `take_int` is 1 for a cycle only if the resolved priority is nonzero, strictly greater than `cur_ipl`, and `ast_req` was zero.
- R8: On a take, `held_ipl`, `held_sum` and `held_valid=1` are registered. An `ack` while `held_valid` is 1 copies the held pair to `intid_out` and `isr_out` and clears `held_valid`. A take in the same cycle sets `held_valid` again.
- R9: A nonzero `ast_req` suppresses the take in that cycle and sets `err_flag`.
- R10: A post or clear with a level `>= NUM_LEVELS` or an index `>= SRC_W` changes no source word, does not alias onto another level, and sets the sticky `err_flag`. Only reset clears `err_flag`.
- R11: An `ack` while `held_valid` is 0 leaves `intid_out` and `isr_out` unchanged and sets `err_flag`.
- R12: A post and a clear to the same bit in the same cycle leave the bit set.
- R13: Synchronous reset zeroes all source words, `pend_levels`, the holding registers, `held_valid`, the outputs and `err_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| post_en | input | 1 | Post command strobe |
| post_lvl | input | LVL_IN_W (6) | Post level number |
| post_idx | input | IDX_IN_W (7) | Post source index |
| clr_en | input | 1 | Clear command strobe |
| clr_lvl | input | LVL_IN_W (6) | Clear level number |
| clr_idx | input | IDX_IN_W (7) | Clear source index |
| clr_all | input | 1 | Wipe all levels |
| sw_req | input | NUM_LEVELS (32) | Software request vector |
| ast_req | input | 4 | Asynchronous trap request (unsupported) |
| cur_ipl | input | IPL_W (5) | Core's current priority level |
| pc_low | input | 2 | Low program-counter bits |
| ack | input | 1 | Core acknowledge / update strobe |
| pend_levels | output | NUM_LEVELS (32) | Per-level pending bits |
| int_possible | output | 1 | Interrupt may be taken now |
| take_int | output | 1 | Take-interrupt pulse |
| held_valid | output | 1 | Holding registers hold an unacknowledged take |
| held_ipl | output | IPL_W (5) | Held priority |
| held_sum | output | NUM_LEVELS (32) | Held summary mask |
| intid_out | output | IPL_W (5) | Interrupt id written on acknowledge |
| isr_out | output | NUM_LEVELS (32) | Interrupt summary written on acknowledge |
| err_flag | output | 1 | Sticky error |

## Verification
A command applied before edge k shows in `pend_levels` right after edge k. Its effect on `int_possible`, `take_int` and the holding registers appears one edge later, because resolution uses the pending bits registered before the edge. Software requests, `cur_ipl`, `pc_low` and `ast_req` act on the next edge, and an `ack` moves the held pair to the outputs at that same edge. The bench's reference model advances once per edge in exactly this order: resolve, then hold/acknowledge, then commands. Every output is compared half a cycle after each edge, so each result is checked in the cycle it is due.

// File: rtl/irq_lvl_pkg.sv
package irq_lvl_pkg;
  // Held result of one resolution step is carried as separate fields; the
  // package keeps the command kinds used in comments and checkers.
  typedef enum logic [1:0] {
    CMD_NONE  = 2'd0,
    CMD_POST  = 2'd1,
    CMD_CLEAR = 2'd2,
    CMD_WIPE  = 2'd3
  } irq_cmd_e;
endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank #(
  parameter int NUM_LEVELS = 32,
  parameter int SRC_W      = 64,
  parameter int LVL_IN_W   = 6,
  parameter int IDX_IN_W   = 7
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  post_en,
  input  logic [LVL_IN_W-1:0]   post_lvl,
  input  logic [IDX_IN_W-1:0]   post_idx,
  input  logic                  clr_en,
  input  logic [LVL_IN_W-1:0]   clr_lvl,
  input  logic [IDX_IN_W-1:0]   clr_idx,
  input  logic                  clr_all,
  output logic [NUM_LEVELS-1:0] pend_q,
  output logic                  cmd_bad
);
  localparam logic [LVL_IN_W-1:0] LVL_LIM = LVL_IN_W'(NUM_LEVELS);
  localparam logic [IDX_IN_W-1:0] IDX_LIM = IDX_IN_W'(SRC_W);

  logic [SRC_W-1:0] words_q [NUM_LEVELS];
  logic [SRC_W-1:0] words_d [NUM_LEVELS];
  logic post_ok, clr_ok;

  assign post_ok = (post_lvl < LVL_LIM) && (post_idx < IDX_LIM);
  assign clr_ok  = (clr_lvl < LVL_LIM) && (clr_idx < IDX_LIM);
  assign cmd_bad = (post_en && !post_ok) || (clr_en && !clr_ok);

  // Clear is applied first so a post to the same bit wins (R12).
  always_comb begin
    for (int l = 0; l < NUM_LEVELS; l++) begin
      words_d[l] = words_q[l];
      if (clr_en && clr_ok && clr_lvl == LVL_IN_W'(l))
        words_d[l][clr_idx] = 1'b0;
      if (post_en && post_ok && post_lvl == LVL_IN_W'(l))
        words_d[l][post_idx] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    for (int l = 0; l < NUM_LEVELS; l++) begin
      if (rst || clr_all) begin
        words_q[l] <= '0;
        pend_q[l]  <= 1'b0;
      end else begin
        words_q[l] <= words_d[l];
        pend_q[l]  <= |words_d[l];
      end
    end
  end

  assert_post_sets_R1: assert property (@(posedge clk) disable iff (rst)
    (post_en && post_ok && !clr_all) |=> pend_q[$past(post_lvl)]);
  assert_wipe_R3: assert property (@(posedge clk) disable iff (rst)
    clr_all |=> (pend_q == '0));
endmodule

// File: rtl/irq_prio_resolve.sv
module irq_prio_resolve #(
  parameter int NUM_LEVELS = 32,
  parameter int IPL_W      = 5,
  parameter int SW_MIN     = 2,
  parameter int SW_MAX     = 16,
  parameter int EXT_MIN    = 16,
  parameter int EXT_MAX    = 32
) (
  input  logic [NUM_LEVELS-1:0] pend,
  input  logic [NUM_LEVELS-1:0] sw_req,
  output logic [IPL_W-1:0]      ipl,
  output logic [NUM_LEVELS-1:0] sum
);
  // Ascending scans: a later (higher) hit overwrites, external scan last.
  always_comb begin
    ipl = '0;
    sum = '0;
    for (int i = SW_MIN; i < SW_MAX; i++) begin
      if (sw_req[i]) begin
        ipl    = IPL_W'(i - SW_MIN + 1);
        sum[i] = 1'b1;
      end
    end
    for (int i = EXT_MIN; i < EXT_MAX; i++) begin
      if (pend[i]) begin
        ipl    = IPL_W'(i);
        sum[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_hold.sv
module irq_hold #(
  parameter int NUM_LEVELS = 32,
  parameter int IPL_W      = 5
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  take,
  input  logic [IPL_W-1:0]      ipl,
  input  logic [NUM_LEVELS-1:0] sum,
  input  logic                  ack,
  output logic                  held_valid,
  output logic [IPL_W-1:0]      held_ipl,
  output logic [NUM_LEVELS-1:0] held_sum,
  output logic [IPL_W-1:0]      intid_out,
  output logic [NUM_LEVELS-1:0] isr_out,
  output logic                  ack_bad
);
  assign ack_bad = ack && !held_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      held_valid <= 1'b0;
      held_ipl   <= '0;
      held_sum   <= '0;
      intid_out  <= '0;
      isr_out    <= '0;
    end else begin
      if (ack && held_valid) begin
        intid_out  <= held_ipl;
        isr_out    <= held_sum;
        held_valid <= 1'b0;
      end
      if (take) begin
        held_ipl   <= ipl;
        held_sum   <= sum;
        held_valid <= 1'b1;
      end
    end
  end

  assert_ack_moves_R8: assert property (@(posedge clk) disable iff (rst)
    (ack && held_valid) |=> (intid_out == $past(held_ipl) && isr_out == $past(held_sum)));
  assert_idle_ack_R11: assert property (@(posedge clk) disable iff (rst)
    (ack && !held_valid) |=> ($stable(intid_out) && $stable(isr_out)));
endmodule

// File: rtl/irq_level_ctrl.sv
module irq_level_ctrl #(
  parameter int NUM_LEVELS = 32,
  parameter int SRC_W      = 64,
  parameter int SW_MIN     = 2,
  parameter int SW_MAX     = 16,
  parameter int EXT_MIN    = 16,
  parameter int EXT_MAX    = 32,
  parameter int AST_W      = 4,
  parameter int IPL_W      = $clog2(NUM_LEVELS),
  parameter int LVL_IN_W   = $clog2(NUM_LEVELS) + 1,
  parameter int IDX_IN_W   = $clog2(SRC_W) + 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  post_en,
  input  logic [LVL_IN_W-1:0]   post_lvl,
  input  logic [IDX_IN_W-1:0]   post_idx,
  input  logic                  clr_en,
  input  logic [LVL_IN_W-1:0]   clr_lvl,
  input  logic [IDX_IN_W-1:0]   clr_idx,
  input  logic                  clr_all,
  input  logic [NUM_LEVELS-1:0] sw_req,
  input  logic [AST_W-1:0]      ast_req,
  input  logic [IPL_W-1:0]      cur_ipl,
  input  logic [1:0]            pc_low,
  input  logic                  ack,
  output logic [NUM_LEVELS-1:0] pend_levels,
  output logic                  int_possible,
  output logic                  take_int,
  output logic                  held_valid,
  output logic [IPL_W-1:0]      held_ipl,
  output logic [NUM_LEVELS-1:0] held_sum,
  output logic [IPL_W-1:0]      intid_out,
  output logic [NUM_LEVELS-1:0] isr_out,
  output logic                  err_flag
);
  import irq_lvl_pkg::*;

  logic [NUM_LEVELS-1:0] pend_q, res_sum;
  logic [IPL_W-1:0]      res_ipl;
  logic cmd_bad, ack_bad, take_d, take_q, poss_q, err_q;
  irq_cmd_e unused_kind;

  assign unused_kind = CMD_NONE;

  irq_src_bank #(.NUM_LEVELS(NUM_LEVELS), .SRC_W(SRC_W),
                 .LVL_IN_W(LVL_IN_W), .IDX_IN_W(IDX_IN_W)) u_bank (
    .clk(clk), .rst(rst),
    .post_en(post_en), .post_lvl(post_lvl), .post_idx(post_idx),
    .clr_en(clr_en), .clr_lvl(clr_lvl), .clr_idx(clr_idx),
    .clr_all(clr_all), .pend_q(pend_q), .cmd_bad(cmd_bad));

  irq_prio_resolve #(.NUM_LEVELS(NUM_LEVELS), .IPL_W(IPL_W),
                     .SW_MIN(SW_MIN), .SW_MAX(SW_MAX),
                     .EXT_MIN(EXT_MIN), .EXT_MAX(EXT_MAX)) u_res (
    .pend(pend_q), .sw_req(sw_req), .ipl(res_ipl), .sum(res_sum));

  assign take_d = (ast_req == '0) && (res_ipl != '0) && (res_ipl > cur_ipl);

  irq_hold #(.NUM_LEVELS(NUM_LEVELS), .IPL_W(IPL_W)) u_hold (
    .clk(clk), .rst(rst), .take(take_d), .ipl(res_ipl), .sum(res_sum),
    .ack(ack), .held_valid(held_valid), .held_ipl(held_ipl),
    .held_sum(held_sum), .intid_out(intid_out), .isr_out(isr_out),
    .ack_bad(ack_bad));

  always_ff @(posedge clk) begin
    if (rst) begin
      take_q <= 1'b0;
      poss_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      take_q <= take_d;
      poss_q <= (pend_q != '0) && (pc_low == 2'b00);
      err_q  <= err_q || cmd_bad || ack_bad || (ast_req != '0);
    end
  end

  assign pend_levels  = pend_q;
  assign take_int     = take_q;
  assign int_possible = poss_q;
  assign err_flag     = err_q;

  assert_boundary_R4: assert property (@(posedge clk) disable iff (rst)
    poss_q |-> ($past(pc_low) == 2'b00));
  assert_take_above_R7: assert property (@(posedge clk) disable iff (rst)
    take_q |-> (held_valid && held_ipl > $past(cur_ipl)));
  assert_trap_blocks_R9: assert property (@(posedge clk) disable iff (rst)
    (ast_req != '0) |=> (!take_q && err_q));
  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    err_q |=> err_q);
endmodule

// File: tb/tb_irq_level_ctrl.sv
module tb_irq_level_ctrl;
  localparam int NL = 32, SW = 64, SWMIN = 2, SWMAX = 16, EXMIN = 16, EXMAX = 32;

  logic clk = 1'b0;
  always #5ns clk = ~clk;

  logic rst, post_en, clr_en, clr_all, ack;
  logic [5:0] post_lvl, clr_lvl;
  logic [6:0] post_idx, clr_idx;
  logic [NL-1:0] sw_req;
  logic [3:0] ast_req;
  logic [4:0] cur_ipl;
  logic [1:0] pc_low;
  logic [NL-1:0] pend_levels, held_sum, isr_out;
  logic int_possible, take_int, held_valid, err_flag;
  logic [4:0] held_ipl, intid_out;

  irq_level_ctrl dut (.*);

  // reference model state
  logic [SW-1:0] m_src [NL];
  logic [NL-1:0] m_pend, m_hs, m_isr;
  logic [4:0] m_hi, m_id;
  logic m_hv, m_take, m_poss, m_err;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(string tag, string nm, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, nm, act, exp);
    end
  endtask

  task automatic model_step();
    int ipl = 0;
    logic [NL-1:0] sm = '0;
    bit tk;
    if (rst) begin
      for (int l = 0; l < NL; l++) m_src[l] = '0;
      m_pend = '0; m_hs = '0; m_isr = '0; m_hi = '0; m_id = '0;
      m_hv = 0; m_take = 0; m_poss = 0; m_err = 0;
      return;
    end
    for (int i = SWMIN; i < SWMAX; i++) if (sw_req[i]) begin ipl = i - SWMIN + 1; sm[i] = 1; end
    for (int i = EXMIN; i < EXMAX; i++) if (m_pend[i]) begin ipl = i; sm[i] = 1; end
    tk = (ast_req == 0) && ipl != 0 && ipl > int'(cur_ipl);
    if (ast_req != 0) m_err = 1;
    if (ack) begin
      if (m_hv) begin m_isr = m_hs; m_id = m_hi; m_hv = 0; end
      else m_err = 1;
    end
    if (tk) begin m_hv = 1; m_hi = 5'(ipl); m_hs = sm; end
    m_take = tk;
    m_poss = (m_pend != 0) && pc_low == 0;
    if (clr_en && !(clr_lvl < NL && clr_idx < SW)) m_err = 1;
    if (post_en && !(post_lvl < NL && post_idx < SW)) m_err = 1;
    if (clr_all) for (int l = 0; l < NL; l++) m_src[l] = '0;
    else begin
      if (clr_en && clr_lvl < NL && clr_idx < SW) m_src[clr_lvl][clr_idx] = 1'b0;
      if (post_en && post_lvl < NL && post_idx < SW) m_src[post_lvl][post_idx] = 1'b1;
    end
    for (int l = 0; l < NL; l++) m_pend[l] = |m_src[l];
  endtask

  task automatic compare();
    chk("R1/R2/R3/R10/R12", "pend_levels", 64'(pend_levels), 64'(m_pend));
    chk("R4", "int_possible", 64'(int_possible), 64'(m_poss));
    chk("R5/R6/R7/R9", "take_int", 64'(take_int), 64'(m_take));
    chk("R8", "held_valid", 64'(held_valid), 64'(m_hv));
    chk("R5/R6", "held_ipl", 64'(held_ipl), 64'(m_hi));
    chk("R5/R6", "held_sum", 64'(held_sum), 64'(m_hs));
    chk("R8/R11", "intid_out", 64'(intid_out), 64'(m_id));
    chk("R8/R11", "isr_out", 64'(isr_out), 64'(m_isr));
    chk("R9/R10/R11", "err_flag", 64'(err_flag), 64'(m_err));
  endtask

  task automatic idle();
    post_en = 0; clr_en = 0; clr_all = 0; ack = 0; ast_req = 0;
    post_lvl = 0; post_idx = 0; clr_lvl = 0; clr_idx = 0;
  endtask

  task automatic step();
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare();
    idle();
  endtask

  task automatic post(int l, int k); post_en = 1; post_lvl = 6'(l); post_idx = 7'(k); endtask
  task automatic clr(int l, int k);  clr_en = 1;  clr_lvl = 6'(l);  clr_idx = 7'(k);  endtask
  task automatic do_reset(); rst = 1; step(); rst = 0; endtask

  initial begin
    #1ms;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    idle(); rst = 1; sw_req = 0; cur_ipl = 0; pc_low = 0;
    @(negedge clk);
    do_reset();
    chk("R13", "reset pend", 64'(pend_levels), 64'h0);           // R13
    chk("R13", "reset valid", 64'(held_valid), 64'h0);

    // R1: post external level 20 bit 5, then bit 63
    post(20, 5); step();
    chk("R1", "pend bit 20", 64'(pend_levels[20]), 64'h1);
    post(20, 63); step();
    step();
    chk("R6", "ext priority", 64'(held_ipl), 64'd20);
    // R2: partial clear keeps pending, full drain drops it
    clr(20, 5); step();
    chk("R2", "pend after partial", 64'(pend_levels[20]), 64'h1);
    clr(20, 63); step();
    chk("R2", "pend after drain", 64'(pend_levels[20]), 64'h0);
    // R8: acknowledge moves held pair
    ack = 1; step();
    chk("R8", "intid", 64'(intid_out), 64'd20);
    // R5: software bits 3 and 9 -> priority 8
    sw_req = 32'h0000_0208; cur_ipl = 0; step();
    chk("R5", "sw priority", 64'(held_ipl), 64'd8);
    chk("R5", "sw summary", 64'(held_sum), 64'h208);
    // R7: equal priority does not take
    cur_ipl = 8; step();
    chk("R7", "equal no take", 64'(take_int), 64'h0);
    // R6: external 17 overrides software 8
    post(17, 0); step(); step();
    chk("R6", "override", 64'(held_ipl), 64'd17);
    sw_req = 0;
    // R12: post and clear to the same bit
    clr(25, 7); post(25, 7); step();
    chk("R12", "post wins", 64'(pend_levels[25]), 64'h1);
    // R3: wipe with a concurrent post
    clr_all = 1; post(30, 1); step();
    chk("R3", "wipe", 64'(pend_levels), 64'h0);
    // R4: pc alignment
    post(3, 2); step(); pc_low = 2'b01; step();
    chk("R4", "misaligned", 64'(int_possible), 64'h0);
    pc_low = 0; step();
    chk("R4", "aligned", 64'(int_possible), 64'h1);
    // R10: out-of-range level 40 must not alias to level 8
    do_reset();
    post(40, 1); step();
    chk("R10", "no alias", 64'(pend_levels[8]), 64'h0);
    chk("R10", "err", 64'(err_flag), 64'h1);
    do_reset();
    post(5, 64); step();
    chk("R10", "bad index", 64'(pend_levels[5]), 64'h0);
    // R11: ack with nothing held
    do_reset();
    ack = 1; step();
    chk("R11", "idle ack err", 64'(err_flag), 64'h1);
    // R9: async trap blocks the take
    do_reset();
    sw_req = 32'h8000; cur_ipl = 0; ast_req = 4'h2; step();
    chk("R9", "trap no take", 64'(take_int), 64'h0);
    sw_req = 0;

    // random traffic against the model
    for (int c = 0; c < 4000; c++) begin
      if (c % 500 == 0) do_reset();
      post_en = $urandom_range(0, 1);
      post_lvl = ($urandom_range(0, 15) == 0) ? 6'($urandom_range(32, 63)) : 6'($urandom_range(0, 31));
      post_idx = ($urandom_range(0, 15) == 0) ? 7'($urandom_range(64, 127)) : 7'($urandom_range(0, 63));
      clr_en = $urandom_range(0, 1);
      clr_lvl = ($urandom_range(0, 3) == 0) ? post_lvl : 6'($urandom_range(0, 31));
      clr_idx = ($urandom_range(0, 3) == 0) ? post_idx : 7'($urandom_range(0, 63));
      clr_all = ($urandom_range(0, 63) == 0);
      sw_req = ($urandom_range(0, 1) == 0) ? 0 : (32'h1 << $urandom_range(0, 31)) | (32'h1 << $urandom_range(0, 31));
      ast_req = ($urandom_range(0, 199) == 0) ? 4'h1 : 4'h0;
      cur_ipl = 5'($urandom_range(0, 31));
      pc_low = 2'($urandom_range(0, 3));
      ack = ($urandom_range(0, 3) == 0);
      step();
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule